// File: doc/BRIEF.md
# Power-Fail Chip-Enable Conditioner

This block sits between a host's active-low chip enable and one or two low-power SRAMs, and it is what lets those SRAMs keep their contents on a battery. While the supply is healthy, the host enable passes straight through to the memories. When the supply sags below the chosen fail threshold, the block blocks the enable. There is one exception: an access already in progress may finish, but only inside a bounded grace window. After that the enable stays blocked until the supply has been good again for a long recovery interval. The block also picks the memory supply source. It selects the battery whenever the supply is under the switchover level, and main power otherwise.

Three digital flags come from external comparators: power good against the higher threshold, power good against the lower threshold, and above-switchover. Each passes through a two-flop synchronizer. A static select pin decides which power-good flag counts. The host enable path is combinational, which keeps the pass-through delay to a single multiplexer. The grace and recovery times are parameters in clock cycles. By default they are derived from the clock frequency, giving 100 µs and 100 ms.

Top module: `pfc_conditioner`

## Requirements
- R1: In the normal state, `memCeN` equals `hostCeN` in the same cycle.
- R2: If the synchronized supply is invalid while in normal and `hostCeN` is high, the state becomes protected. While protected, `memCeN` is 1 whatever `hostCeN` does.
- R3: If the supply turns invalid while in normal with `hostCeN` low, the state becomes grace. In grace `memCeN` follows `hostCeN`, and the first clock edge that samples `hostCeN` high moves the state to protected.
- R4: Grace lasts at most `WP_CYCLES` cycles. If the access has not ended by then, the state becomes protected and `memCeN` is 1 even with `hostCeN` still low.
- R5: With `thrSel` = 0 the supply is valid when `pgoodHi` is 1. With `thrSel` = 1 it is valid when `pgoodLo` is 1.
- R6: `useBattery` is 1 when the synchronized `aboveSwitch` is 0, and 0 when it is 1. Every power flag reaches the logic through two flops.
- R7: Once the supply is valid in protected, the state is recovering for exactly `REC_CYCLES` cycles, with `memCeN` held at 1.
- R8: A recovery that has run its full length while `hostCeN` is low stays in recovering. It enters normal only on an edge that samples `hostCeN` high.
- R9: During and right after reset the state is protected, `memCeN` is 1 and `useBattery` is 1.
- R10: If the supply becomes valid during grace or protected, a full recovery starts.
- R11: `stateOut` encodes normal = 0, grace = 1, protected = 2, recovering = 3.
- R12: If the supply turns invalid during recovering, the state returns to protected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostCeN | input | 1 | Host chip enable, active low |
| pgoodHi | input | 1 | Supply above the higher fail threshold |
| pgoodLo | input | 1 | Supply above the lower fail threshold |
| thrSel | input | 1 | Threshold choice: 0 selects the higher threshold, 1 the lower |
| aboveSwitch | input | 1 | Supply above the battery switchover level |
| memCeN | output | 1 | Conditioned chip enable to the SRAMs, active low |
| useBattery | output | 1 | 1 selects battery as the SRAM supply |
| stateOut | output | 2 | Current state code |

## Verification
The bench builds the block with `WP_CYCLES` = 12 and `REC_CYCLES` = 30, in place of the frequency-derived defaults. With those values, an expired grace window, a complete recovery and a recovery that waits for the enable to be re-asserted all fit in tens of cycles. That leaves room for thousands of random cycles in which power drops, returns and toggles mid-window many times. The short windows are what make the exact grace and recovery lengths countable, and what bring a supply flip inside each window within reach of the random phase.

// File: rtl/pfc_pkg.sv
package pfc_pkg;

  typedef enum logic [1:0] {
    ST_NORMAL  = 2'd0,
    ST_GRACE   = 2'd1,
    ST_PROTECT = 2'd2,
    ST_RECOVER = 2'd3
  } pfcState_t;

  // strobes from control to the interval counter
  typedef struct packed {
    logic clr;
    logic run;
  } tmrCmd_t;

endpackage

// File: rtl/pfc_sync.sv
module pfc_sync #(
  parameter int WIDTH = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stage1;

  // both stages reset to 0: power is treated as bad until proven good
  always_ff @(posedge clk) begin
    if (!rstN) begin
      stage1 <= '0;
      dout   <= '0;
    end else begin
      stage1 <= din;
      dout   <= stage1;
    end
  end

endmodule

// File: rtl/pfc_timer.sv
module pfc_timer
  import pfc_pkg::*;
#(
  parameter int WP_CYCLES  = 5000,
  parameter int REC_CYCLES = 5000000
) (
  input  logic    clk,
  input  logic    rstN,
  input  tmrCmd_t cmd,
  output logic    wpExpired,
  output logic    recExpired
);

  localparam int MAXC = (WP_CYCLES > REC_CYCLES) ? WP_CYCLES : REC_CYCLES;
  localparam int CW   = $clog2(MAXC + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rstN)                                   cnt <= '0;
    else if (cmd.clr)                            cnt <= '0;
    else if (cmd.run && cnt != CW'(MAXC))        cnt <= cnt + 1'b1;
  end

  assign wpExpired  = (cnt == CW'(WP_CYCLES - 1));
  assign recExpired = (cnt >= CW'(REC_CYCLES - 1));

  // the counter never runs past its saturation limit
  assert_cnt_bounded_R4: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= CW'(MAXC));

endmodule

// File: rtl/pfc_ctrl.sv
module pfc_ctrl
  import pfc_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      supplyOk,
  input  logic      hostCeN,
  input  logic      wpExpired,
  input  logic      recExpired,
  output pfcState_t state,
  output tmrCmd_t   cmd
);

  pfcState_t nextState;

  always_comb begin
    nextState = state;
    cmd       = '0;
    unique case (state)
      ST_NORMAL: begin
        if (!supplyOk) begin
          nextState = hostCeN ? ST_PROTECT : ST_GRACE;
          cmd.clr   = 1'b1;
        end
      end
      ST_GRACE: begin
        if (supplyOk) begin
          nextState = ST_RECOVER;
          cmd.clr   = 1'b1;
        end else if (hostCeN || wpExpired) begin
          nextState = ST_PROTECT;
        end else begin
          cmd.run = 1'b1;
        end
      end
      ST_PROTECT: begin
        if (supplyOk) begin
          nextState = ST_RECOVER;
          cmd.clr   = 1'b1;
        end
      end
      ST_RECOVER: begin
        if (!supplyOk)        nextState = ST_PROTECT;
        else if (!recExpired) cmd.run   = 1'b1;
        else if (hostCeN)     nextState = ST_NORMAL;
      end
      default: nextState = ST_PROTECT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_PROTECT;
    else       state <= nextState;
  end

  assert_fail_leaves_normal_R2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_NORMAL && !supplyOk) |=> (state != ST_NORMAL));

  assert_grace_entry_R3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_NORMAL && !supplyOk && !hostCeN) |=> (state == ST_GRACE));

  assert_grace_timeout_R4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_GRACE && !supplyOk && wpExpired) |=> (state == ST_PROTECT));

  assert_full_recovery_R7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RECOVER && !recExpired) |=> (state != ST_NORMAL));

  assert_reassert_needed_R8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RECOVER && !hostCeN) |=> (state != ST_NORMAL));

  assert_return_starts_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_GRACE || state == ST_PROTECT) && supplyOk) |=> (state == ST_RECOVER));

  assert_recover_fail_R12: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RECOVER && !supplyOk) |=> (state == ST_PROTECT));

endmodule

// File: rtl/pfc_conditioner.sv
module pfc_conditioner
  import pfc_pkg::*;
#(
  parameter int CLK_HZ     = 50000000,
  parameter int WP_CYCLES  = (CLK_HZ / 1000000) * 100,
  parameter int REC_CYCLES = (CLK_HZ / 1000) * 100
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       hostCeN,
  input  logic       pgoodHi,
  input  logic       pgoodLo,
  input  logic       thrSel,
  input  logic       aboveSwitch,
  output logic       memCeN,
  output logic       useBattery,
  output logic [1:0] stateOut
);

  localparam int NFLAGS = 3;
  localparam int IDX_HI = 0;
  localparam int IDX_LO = 1;
  localparam int IDX_SW = 2;

  logic [NFLAGS-1:0] flagsSync;
  logic              supplyOk;
  logic              wpExpired;
  logic              recExpired;
  pfcState_t         state;
  tmrCmd_t           cmd;

  pfc_sync #(.WIDTH(NFLAGS)) sync_i (
    .clk (clk),
    .rstN(rstN),
    .din ({aboveSwitch, pgoodLo, pgoodHi}),
    .dout(flagsSync)
  );

  assign supplyOk = thrSel ? flagsSync[IDX_LO] : flagsSync[IDX_HI];

  pfc_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .supplyOk  (supplyOk),
    .hostCeN   (hostCeN),
    .wpExpired (wpExpired),
    .recExpired(recExpired),
    .state     (state),
    .cmd       (cmd)
  );

  pfc_timer #(.WP_CYCLES(WP_CYCLES), .REC_CYCLES(REC_CYCLES)) timer_i (
    .clk       (clk),
    .rstN      (rstN),
    .cmd       (cmd),
    .wpExpired (wpExpired),
    .recExpired(recExpired)
  );

  // pass-through only in normal and grace; combinational for minimal delay
  assign memCeN     = (state == ST_NORMAL || state == ST_GRACE) ? hostCeN : 1'b1;
  assign useBattery = ~flagsSync[IDX_SW];
  assign stateOut   = state;

  assert_blocked_enable_R7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RECOVER) |-> memCeN);

  assert_battery_tracks_R6: assert property (@(posedge clk) disable iff (!rstN)
    $past(flagsSync[IDX_SW]) |-> $past(useBattery) == 1'b0);

endmodule

// File: tb/pfc_conditioner_tb.sv
module pfc_conditioner_tb_top;

  localparam int WP  = 12;
  localparam int REC = 30;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostCeN = 1'b1, pgoodHi = 1'b0, pgoodLo = 1'b0, thrSel = 1'b0, aboveSwitch = 1'b0;
  logic memCeN, useBattery;
  logic [1:0] stateOut;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  pfc_conditioner #(.CLK_HZ(50000000), .WP_CYCLES(WP), .REC_CYCLES(REC)) dut_i (
    .clk(clk), .rstN(rstN), .hostCeN(hostCeN), .pgoodHi(pgoodHi), .pgoodLo(pgoodLo),
    .thrSel(thrSel), .aboveSwitch(aboveSwitch), .memCeN(memCeN),
    .useBattery(useBattery), .stateOut(stateOut)
  );

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // reference model built from the requirements
  int mH1, mH2, mL1, mL2, mS1, mS2, mSt, mCnt;
  always @(posedge clk) begin
    int ok;
    if (!rstN) begin
      mH1 = 0; mH2 = 0; mL1 = 0; mL2 = 0; mS1 = 0; mS2 = 0; mSt = 2; mCnt = 0;
    end else begin
      ok = thrSel ? mL2 : mH2;
      case (mSt)
        0: if (ok == 0) begin mSt = hostCeN ? 2 : 1; mCnt = 0; end
        1: if (ok != 0) begin mSt = 3; mCnt = 0; end
           else if (hostCeN || mCnt == WP - 1) mSt = 2;
           else mCnt++;
        2: if (ok != 0) begin mSt = 3; mCnt = 0; end
        default: if (ok == 0) mSt = 2;
                 else if (mCnt < REC - 1) mCnt++;
                 else if (hostCeN) mSt = 0;
      endcase
      mH2 = mH1; mH1 = pgoodHi;
      mL2 = mL1; mL1 = pgoodLo;
      mS2 = mS1; mS1 = aboveSwitch;
    end
  end

  function automatic int expCe(int st, logic host);
    return (st <= 1) ? int'(host) : 1;
  endfunction

  // continuous comparison against the model, away from both edges
  always @(negedge clk) begin
    #2;
    if (rstN && !finished) begin
      chk("R11 state", stateOut, mSt);
      chk("R1 memCeN", memCeN, expCe(mSt, hostCeN));
      chk("R6 useBattery", useBattery, (mS2 == 0) ? 1 : 0);
    end
  end

  task automatic step();
    @(negedge clk); #5;
  endtask

  task automatic waitState(input int s);
    for (int i = 0; i < 1000 && stateOut != s; i++) step();
  endtask

  task automatic countIn(input int s, output int n);
    n = 0;
    while (stateOut == s && n < 1000) begin n++; step(); end
  endtask

  task automatic finish();
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    int n;
    void'($urandom(1234));
    repeat (3) step();
    // R9 reset state
    chk("R9 state", stateOut, 2);
    chk("R9 memCeN", memCeN, 1);
    chk("R9 useBattery", useBattery, 1);
    rstN = 1'b1;
    step();
    chk("R9 after reset state", stateOut, 2);
    // power up; R7 recovery length, R6 battery release
    pgoodHi = 1; pgoodLo = 1; aboveSwitch = 1; hostCeN = 1;
    step(); chk("R6 one flop not enough", useBattery, 1);
    step(); chk("R6 battery off", useBattery, 0);
    waitState(3);
    hostCeN = 0; step();
    chk("R7 memCeN blocked", memCeN, 1);
    hostCeN = 1;
    countIn(3, n);
    chk("R7 recovery cycles", n + 1, REC);
    chk("R7 then normal", stateOut, 0);
    // R1 pass-through
    hostCeN = 0; #1 chk("R1 low", memCeN, 0);
    hostCeN = 1; #1 chk("R1 high", memCeN, 1);
    // R5 thrSel=0 ignores pgoodLo
    pgoodLo = 0; repeat (4) step();
    chk("R5 lo ignored", stateOut, 0);
    // R2 fail with host idle
    pgoodHi = 0; repeat (4) step();
    chk("R2 protected", stateOut, 2);
    hostCeN = 0; #1 chk("R2 memCeN forced", memCeN, 1);
    // R8 recovery completed with host low
    pgoodHi = 1; waitState(3);
    repeat (REC + 5) step();
    chk("R8 held", stateOut, 3);
    chk("R8 memCeN", memCeN, 1);
    hostCeN = 1; step(); step();
    chk("R8 normal after release", stateOut, 0);
    // R4 grace timeout
    hostCeN = 0; pgoodHi = 0;
    waitState(1);
    chk("R3 grace pass", memCeN, 0);
    countIn(1, n);
    chk("R4 grace cycles", n, WP);
    chk("R4 protected", stateOut, 2);
    chk("R4 memCeN with host low", memCeN, 1);
    // R10 return during protect
    pgoodHi = 1; hostCeN = 1; waitState(3);
    chk("R10 recovering", stateOut, 3);
    // R12 fail during recovery
    pgoodHi = 0; repeat (3) step();
    chk("R12 protected", stateOut, 2);
    pgoodHi = 1; waitState(0);
    // R3 grace ended by host
    hostCeN = 0; pgoodHi = 0; waitState(1);
    step(); step(); hostCeN = 1; step();
    chk("R3 protected after deassert", stateOut, 2);
    // R10 return during grace
    pgoodHi = 1; waitState(3); waitState(0);
    hostCeN = 0; pgoodHi = 0; waitState(1);
    pgoodHi = 1; step(); step(); step();
    chk("R10 grace to recover", stateOut, 3);
    // R5 thrSel=1 uses pgoodLo
    hostCeN = 1; thrSel = 1; pgoodLo = 1; waitState(0);
    pgoodHi = 0; repeat (4) step();
    chk("R5 hi ignored", stateOut, 0);
    pgoodLo = 0; repeat (4) step();
    chk("R5 lo used", stateOut, 2);
    // R6 battery on
    aboveSwitch = 0; step(); step();
    chk("R6 battery on", useBattery, 1);
    // random phase checked by the model
    for (int i = 0; i < 6000; i++) begin
      if ($urandom % 4 == 0)  hostCeN = ~hostCeN;
      if ($urandom % 60 == 0) pgoodHi = ~pgoodHi;
      if ($urandom % 60 == 0) pgoodLo = ~pgoodLo;
      if ($urandom % 400 == 0) thrSel = ~thrSel;
      if ($urandom % 80 == 0) aboveSwitch = ~aboveSwitch;
      step();
    end
    step();
    finish();
  end

endmodule